// File: doc/BRIEF.md
# Two-Channel Break Condition Sequencer

This block sits behind two comparator channels of a debug unit and turns their per-cycle match strobes into one break request to the processor. Channel A and channel B each report a hit as a one-cycle strobe. A mode register picks how the two are combined. In parallel mode either channel raises a break on its own. In chained mode channel A only arms the unit, and a later channel B hit fires the break.

Channel B can also be told to fire only on a chosen occurrence. A 12-bit occurrence counter, which software reads and writes through a 16-bit register slot, counts down once per qualifying B hit. The break fires on the qualifying hit that arrives while the counter holds one. Software reaches both registers through a small port with a write strobe, a one-bit register select and combinational read data. The break request is registered and appears one clock after the cycle of the hit that caused it.

Top module: `brk_seq_top`

## Requirements
- R1: After reset the mode register reads 0x0000, the occurrence counter reads 0x0000 and `brk_req` is low.
- R2: In the mode register (`reg_sel`=0) bit 4 selects chained mode and bit 0 enables occurrence counting. All other bits read 0 whatever was written. The mode changes only on a write.
- R3: In the counter register (`reg_sel`=1) bits 11:0 are writable and read back. Bits 15:12 always read 0, so the largest count is 4095.
- R4: In parallel mode a hit on A, on B, or on both in the same cycle raises `brk_req` in the next cycle. This holds whether or not counting is enabled for A.
- R5: `brk_req` is high for exactly one cycle per cycle that contains a firing hit, and is low when there is no hit.
- R6: In chained mode an A hit alone never raises a break, and a B hit without a prior A hit raises no break. A B hit after an A hit does raise one.
- R7: In chained mode the armed state is cleared by a break and by any write to the mode register. A later B hit then needs a new A hit.
- R8: In chained mode, when A and B hit in the same cycle, that B hit does not qualify. The A hit still arms the unit for later B hits.
- R9: With counting enabled, each qualifying B hit lowers the counter by one. No break occurs while the counter held more than one before the hit. This holds in both modes.
- R10: With counting enabled, a qualifying B hit while the counter holds 1 raises a break and leaves the counter at 0.
- R11: With counting enabled and the counter at 0, a qualifying B hit breaks at once and the counter stays at 0.
- R12: A counter write in the same cycle as a qualifying B hit wins. The counter takes the written value and is not lowered.
- R13: With counting disabled, every qualifying B hit breaks and the counter is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_hit | input | 1 | Channel A match strobe |
| b_hit | input | 1 | Channel B match strobe |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 mode, 1 occurrence counter |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data of the selected register |
| brk_req | output | 1 | Break request pulse, one cycle after the hit |

## Verification
Single strobes on A, on B and on both together are driven in parallel mode to show that each channel fires on its own and that a coincident pair yields one pulse. In chained mode the bench drives four kinds of stimulus, and each separates arming from qualifying:
- A alone, then B.
- B with no prior A.
- A and B together.
- A, then a mode write, then B.

Counter runs from 3, from 2 and from 0 show whether the counter lowers, where it stops and when it fires. A write that collides with a hit shows which of the two wins.

// File: rtl/brk_seq_pkg.sv
package brk_seq_pkg;
    localparam int REG_W     = 16;
    localparam int CNT_W     = 12;
    localparam int CHAIN_BIT = 4;
    localparam int CNTEN_BIT = 0;

    typedef struct packed {
        logic chain;
        logic cnt_en;
    } brk_mode_t;

    typedef enum logic {
        SEL_MODE  = 1'b0,
        SEL_COUNT = 1'b1
    } reg_sel_e;

    function automatic brk_mode_t unpack_mode(input logic [REG_W-1:0] w);
        brk_mode_t m;
        m.chain  = w[CHAIN_BIT];
        m.cnt_en = w[CNTEN_BIT];
        return m;
    endfunction

    function automatic logic [REG_W-1:0] pack_mode(input brk_mode_t m);
        logic [REG_W-1:0] w;
        w = '0;
        w[CHAIN_BIT] = m.chain;
        w[CNTEN_BIT] = m.cnt_en;
        return w;
    endfunction
endpackage

// File: rtl/brk_mode_reg.sv
module brk_mode_reg
    import brk_seq_pkg::*;
#(
    parameter int DATA_W = REG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output brk_mode_t         mode,
    output logic [DATA_W-1:0] rd_val
);
    always_ff @(posedge clk) begin
        if (rst)        mode <= '0;
        else if (wr_en) mode <= unpack_mode(wdata);
    end

    assign rd_val = pack_mode(mode);

    // R2: mode only moves on a write
    p_mode_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_en) |-> (mode == $past(mode)));
endmodule

// File: rtl/brk_occ_counter.sv
module brk_occ_counter
    import brk_seq_pkg::*;
#(
    parameter int WIDTH  = CNT_W,
    parameter int DATA_W = REG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              qual_b,
    input  logic              cnt_en,
    output logic              fire,
    output logic [DATA_W-1:0] rd_val
);
    localparam int PAD_W = DATA_W - WIDTH;

    logic [WIDTH-1:0] cnt;
    logic             at_floor;
    logic             dec;

    assign at_floor = (cnt == '0);
    assign dec      = qual_b && cnt_en && !at_floor;
    assign fire     = qual_b && cnt_en && (cnt <= WIDTH'(1));

    always_ff @(posedge clk) begin
        if (rst)        cnt <= '0;
        else if (wr_en) cnt <= wdata[WIDTH-1:0];
        else if (dec)   cnt <= cnt - 1'b1;
    end

    generate
        if (PAD_W > 0) begin : g_pad
            assign rd_val = {{PAD_W{1'b0}}, cnt};
        end else begin : g_nopad
            assign rd_val = cnt;
        end
    endgenerate

    // R9: one step down per qualifying hit
    p_dec_one_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(dec) && !$past(wr_en)) |-> (cnt == $past(cnt) - 1'b1));
    // R11: no wrap below zero
    p_no_wrap_r11: assert property (@(posedge clk) disable iff (rst)
        (($past(cnt) == '0) && !$past(wr_en)) |-> (cnt == '0));
    // R12: write beats decrement
    p_wr_wins_r12: assert property (@(posedge clk) disable iff (rst)
        $past(wr_en) |-> (cnt == $past(wdata[WIDTH-1:0])));
endmodule

// File: rtl/brk_arm.sv
module brk_arm (
    input  logic clk,
    input  logic rst,
    input  logic chain,
    input  logic a_hit,
    input  logic clr,
    output logic armed
);
    always_ff @(posedge clk) begin
        if (rst || clr || !chain) armed <= 1'b0;
        else if (a_hit)           armed <= 1'b1;
    end

    // R7: a break or mode write disarms
    p_clr_r7: assert property (@(posedge clk) disable iff (rst)
        $past(clr) |-> !armed);
    // R8: an A hit in chained mode arms for later
    p_arm_r8: assert property (@(posedge clk) disable iff (rst)
        $past(a_hit && chain && !clr) |-> armed);
endmodule

// File: rtl/brk_seq_top.sv
module brk_seq_top
    import brk_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        a_hit,
    input  logic        b_hit,
    input  logic        reg_we,
    input  logic        reg_sel,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        brk_req
);
    reg_sel_e         sel;
    brk_mode_t        mode;
    logic             mode_we;
    logic             cnt_we;
    logic [REG_W-1:0] mode_rd;
    logic [REG_W-1:0] cnt_rd;
    logic             armed;
    logic             qual_b;
    logic             cnt_fire;
    logic             brk_now;

    assign sel     = reg_sel_e'(reg_sel);
    assign mode_we = reg_we && (sel == SEL_MODE);
    assign cnt_we  = reg_we && (sel == SEL_COUNT);

    brk_mode_reg #(.DATA_W(REG_W)) u_mode (
        .clk(clk), .rst(rst), .wr_en(mode_we), .wdata(reg_wdata),
        .mode(mode), .rd_val(mode_rd)
    );

    brk_arm u_arm (
        .clk(clk), .rst(rst), .chain(mode.chain), .a_hit(a_hit),
        .clr(brk_now || mode_we), .armed(armed)
    );

    assign qual_b = b_hit && (!mode.chain || armed);

    brk_occ_counter #(.WIDTH(CNT_W), .DATA_W(REG_W)) u_cnt (
        .clk(clk), .rst(rst), .wr_en(cnt_we), .wdata(reg_wdata),
        .qual_b(qual_b), .cnt_en(mode.cnt_en), .fire(cnt_fire),
        .rd_val(cnt_rd)
    );

    assign brk_now = (a_hit && !mode.chain) ||
                     (qual_b && (!mode.cnt_en || cnt_fire));

    always_ff @(posedge clk) begin
        if (rst) brk_req <= 1'b0;
        else     brk_req <= brk_now;
    end

    assign reg_rdata = (sel == SEL_COUNT) ? cnt_rd : mode_rd;

    // R4: a pulse always traces back to a hit
    p_pulse_src_r4: assert property (@(posedge clk) disable iff (rst)
        brk_req |-> ($past(a_hit) || $past(b_hit)));
    // R6: a lone A hit in chained mode stays silent
    p_chain_a_silent_r6: assert property (@(posedge clk) disable iff (rst)
        $past(mode.chain && a_hit && !b_hit) |-> !brk_req);
endmodule

// File: tb/test_brk_seq_top.sv
module test_brk_seq_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        a_hit = 1'b0;
    logic        b_hit = 1'b0;
    logic        reg_we = 1'b0;
    logic        reg_sel = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        brk_req;
    int          n_chk = 0;
    int          n_bad = 0;
    int          cyc = 0;

    always #2.5 clk = ~clk;

    brk_seq_top i_brk_seq_top (
        .clk(clk), .rst(rst), .a_hit(a_hit), .b_hit(b_hit),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .brk_req(brk_req)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic s, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic s, input logic [15:0] exp);
        reg_sel = s;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic hit(input string tag, input logic a, input logic b, input logic exp);
        @(negedge clk);
        a_hit = a; b_hit = b;
        @(negedge clk);
        a_hit = 1'b0; b_hit = 1'b0;
        chk(tag, {15'b0, brk_req}, {15'b0, exp});
    endtask

    task automatic t_reset;
        rd_chk("R1 mode", 1'b0, 16'h0000);
        rd_chk("R1 count", 1'b1, 16'h0000);
        chk("R1 brk", {15'b0, brk_req}, 16'h0000);
    endtask

    task automatic t_regs;
        wr(1'b0, 16'hFFFF);
        rd_chk("R2 reserved", 1'b0, 16'h0011);
        wr(1'b0, 16'h0000);
        rd_chk("R2 clear", 1'b0, 16'h0000);
        wr(1'b1, 16'hFFFF);
        rd_chk("R3 max", 1'b1, 16'h0FFF);
        wr(1'b1, 16'hABCD);
        rd_chk("R3 mask", 1'b1, 16'h0BCD);
    endtask

    task automatic t_parallel;
        wr(1'b0, 16'h0000);
        hit("R4 A", 1'b1, 1'b0, 1'b1);
        @(negedge clk);
        chk("R5 one cycle", {15'b0, brk_req}, 16'h0000);
        hit("R4 B", 1'b0, 1'b1, 1'b1);
        hit("R4 both", 1'b1, 1'b1, 1'b1);
        hit("R5 idle", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_chain;
        wr(1'b0, 16'h0010);
        hit("R6 A alone", 1'b1, 1'b0, 1'b0);
        wr(1'b0, 16'h0010);
        hit("R6 B unarmed", 1'b0, 1'b1, 1'b0);
        hit("R6 arm", 1'b1, 1'b0, 1'b0);
        hit("R6 B armed", 1'b0, 1'b1, 1'b1);
        hit("R7 after break", 1'b0, 1'b1, 1'b0);
        hit("R7 rearm", 1'b1, 1'b0, 1'b0);
        wr(1'b0, 16'h0010);
        hit("R7 after write", 1'b0, 1'b1, 1'b0);
        hit("R8 same cycle", 1'b1, 1'b1, 1'b0);
        hit("R8 later B", 1'b0, 1'b1, 1'b1);
    endtask

    task automatic t_count;
        wr(1'b0, 16'h0001);
        wr(1'b1, 16'h0003);
        hit("R9 3->2", 1'b0, 1'b1, 1'b0);
        rd_chk("R9 count 2", 1'b1, 16'h0002);
        hit("R9 2->1", 1'b0, 1'b1, 1'b0);
        rd_chk("R9 count 1", 1'b1, 16'h0001);
        hit("R10 fire", 1'b0, 1'b1, 1'b1);
        rd_chk("R10 count 0", 1'b1, 16'h0000);
        hit("R11 fire at 0", 1'b0, 1'b1, 1'b1);
        rd_chk("R11 stays 0", 1'b1, 16'h0000);
        hit("R4 A with count", 1'b1, 1'b0, 1'b1);
        wr(1'b1, 16'h0005);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = 1'b1; reg_wdata = 16'h0009; b_hit = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; b_hit = 1'b0;
        chk("R12 no brk", {15'b0, brk_req}, 16'h0000);
        rd_chk("R12 write wins", 1'b1, 16'h0009);
    endtask

    task automatic t_nocount;
        wr(1'b0, 16'h0000);
        wr(1'b1, 16'h0002);
        hit("R13 B breaks", 1'b0, 1'b1, 1'b1);
        rd_chk("R13 count kept", 1'b1, 16'h0002);
    endtask

    task automatic t_chain_count;
        wr(1'b0, 16'h0011);
        wr(1'b1, 16'h0002);
        hit("R9 chain arm", 1'b1, 1'b0, 1'b0);
        hit("R9 chain 2->1", 1'b0, 1'b1, 1'b0);
        rd_chk("R9 chain count", 1'b1, 16'h0001);
        hit("R10 chain fire", 1'b0, 1'b1, 1'b1);
        rd_chk("R10 chain zero", 1'b1, 16'h0000);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regs();
        t_parallel();
        t_chain();
        t_count();
        t_nocount();
        t_chain_count();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule